// File: doc/BRIEF.md
# Byte-Lane Banked Memory with Unaligned Word Access

This block is a byte-addressable storage array with a 32-bit data port. It reads or writes a full word at any byte address in one access, including addresses that are not multiples of four. Storage is split into four byte-wide synchronous banks, and each bank holds one byte lane.

For every request, each bank receives either the requested row or the row after it. The read data from the banks is rotated back into request byte order. Write data and write byte enables are rotated the other way, so each byte reaches the bank that owns its address.

A request is one cycle with `req_valid` high. It carries a byte address, a read/write flag and, for writes, per-byte enables and data. A read answers on the following clock edge with `rsp_valid` and `rsp_rdata`. Addresses that run past the top of the array wrap to the bottom.

Top module: `skew_word_mem`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rsp_valid` is low.
- R2: Each read request (`req_valid`=1, `req_write`=0) produces exactly one cycle of `rsp_valid`=1 on the following clock edge. A write request or an idle cycle produces `rsp_valid`=0 on the following edge.
- R3: A read at a byte address A with A mod 4 = 0 returns the byte stored at A+i on `rsp_rdata[8i+7:8i]`, for i = 0..3 (little-endian).
- R4: A read at a byte address with A mod 4 = 1, 2 or 3 returns the same byte layout as R3 in a single access. The banks for lanes below the offset read from the next row.
- R5: A write stores `req_wdata[8i+7:8i]` at byte address A+i for each i where `req_be[i]` is 1. Bytes whose enable bit is 0 keep their old value. This holds for 1-, 2- and 4-byte enable patterns at every offset.
- R6: Byte addresses A+i that exceed 2^ADDR_W-1 wrap to (A+i) mod 2^ADDR_W, for both reads and writes.
- R7: A read issued in the cycle directly after a write returns the newly written bytes wherever the two accesses overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of byte 0 of the access |
| req_be | input | 4 | Write byte enables, bit i for byte i |
| req_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, byte i in bits 8i+7:8i |

## Verification
The bench targets every byte offset, for both reads and masked writes. A design that gave the wrong lanes the next row, or rotated in the wrong direction, would return bytes in the wrong order. It would also return bytes from a neighbouring word, or write into it. Accesses near the top address check the wrap: a design that carried into a missing row bit would read or corrupt the wrong row instead of row zero. Sparse enable patterns and writes followed directly by reads expose two further faults: disabled bytes being overwritten, and stale data being returned.

// File: rtl/skew_mem_pkg.sv
package skew_mem_pkg;
  localparam int OFF_W  = 2;
  localparam int LANES  = 1 << OFF_W;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  // A lane whose index is below the byte offset holds a byte of the next row.
  function automatic logic lane_takes_next_row(input int lane, input logic [OFF_W-1:0] off);
    return OFF_W'(lane) < off;
  endfunction

  // Source lane for output element j of a rotation by off elements.
  // Right rotation (read path): out[j] = in[j+off]; left (write path): out[j] = in[j-off].
  function automatic logic [OFF_W-1:0] lane_src(input int j, input logic [OFF_W-1:0] off,
                                                input bit to_left);
    logic [OFF_W-1:0] jj;
    jj = OFF_W'(j);
    return to_left ? (jj - off) : (jj + off);
  endfunction
endpackage

// File: rtl/skew_lane_addr.sv
module skew_lane_addr
  import skew_mem_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic [ROW_W-1:0]             row,
  input  logic [OFF_W-1:0]             off,
  output logic [LANES-1:0]             lane_inc,
  output logic [LANES-1:0][ROW_W-1:0]  lane_row
);
  logic [ROW_W-1:0] row_next;

  // Natural ROW_W-bit overflow gives the wrap from the last row to row 0.
  assign row_next = row + ROW_W'(1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_inc[k] = lane_takes_next_row(k, off);
    assign lane_row[k] = lane_inc[k] ? row_next : row;
  end
endmodule

// File: rtl/skew_bank.sv
module skew_bank #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/skew_rotator.sv
module skew_rotator
  import skew_mem_pkg::*;
#(
  parameter int EL_W    = 8,
  parameter bit TO_LEFT = 1'b0
) (
  input  logic [LANES-1:0][EL_W-1:0] din,
  input  logic [OFF_W-1:0]           off,
  output logic [LANES-1:0][EL_W-1:0] dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_el
    assign dout[j] = din[lane_src(j, off, TO_LEFT)];
  end
endmodule

// File: rtl/skew_word_mem.sv
module skew_word_mem
  import skew_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic                           req_rd;
  logic                           req_wr;
  logic [ROW_W-1:0]               req_row;
  logic [OFF_W-1:0]               req_off;
  logic [OFF_W-1:0]               off_q;
  logic [LANES-1:0]               lane_inc;
  logic [LANES-1:0][ROW_W-1:0]    lane_row;
  logic [LANES-1:0][BYTE_W-1:0]   bank_wdata;
  logic [LANES-1:0][BYTE_W-1:0]   bank_rdata;
  logic [LANES-1:0][BYTE_W-1:0]   word_out;
  logic [LANES-1:0]               bank_be;
  logic [LANES-1:0]               bank_en;
  logic [LANES-1:0]               bank_we;

  assign req_rd  = req_valid & ~req_write;
  assign req_wr  = req_valid &  req_write;
  assign req_row = req_addr[ADDR_W-1:OFF_W];
  assign req_off = req_addr[OFF_W-1:0];

  skew_lane_addr #(.ROW_W(ROW_W)) lane_addr_i (
    .row      (req_row),
    .off      (req_off),
    .lane_inc (lane_inc),
    .lane_row (lane_row)
  );

  skew_rotator #(.EL_W(BYTE_W), .TO_LEFT(1'b1)) wdata_rot_i (
    .din  (req_wdata),
    .off  (req_off),
    .dout (bank_wdata)
  );

  skew_rotator #(.EL_W(1), .TO_LEFT(1'b1)) be_rot_i (
    .din  (req_be),
    .off  (req_off),
    .dout (bank_be)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    assign bank_we[k] = req_wr & bank_be[k];
    assign bank_en[k] = req_rd | bank_we[k];

    skew_bank #(.ROW_W(ROW_W), .DATA_W(BYTE_W)) bank_i (
      .clk   (clk),
      .en    (bank_en[k]),
      .we    (bank_we[k]),
      .addr  (lane_row[k]),
      .wdata (bank_wdata[k]),
      .rdata (bank_rdata[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      off_q     <= '0;
    end else begin
      rsp_valid <= req_rd;
      if (req_rd) off_q <= req_off;
    end
  end

  skew_rotator #(.EL_W(BYTE_W), .TO_LEFT(1'b0)) rdata_rot_i (
    .din  (bank_rdata),
    .off  (off_q),
    .dout (word_out)
  );

  assign rsp_rdata = word_out;
endmodule

// File: rtl/skew_word_mem_chk.sv
module skew_word_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              rsp_valid,
  input logic [3:0]        lane_inc,
  input logic [3:0]        bank_we
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !rsp_valid);

  // R2
  a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2
  a_r2_silent_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R4: the number of lanes moved to the next row equals the byte offset, never lane 3
  a_r4_next_row_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(lane_inc) == int'(req_addr[1:0])) && !lane_inc[3]);

  // R5: a write touches exactly as many banks as it enables bytes
  a_r5_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> ($countones(bank_we) == $countones(req_be)));

  // R5: nothing is written without a write request
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |-> (bank_we == 4'b0000));
endmodule

bind skew_word_mem skew_word_mem_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .rsp_valid (rsp_valid),
  .lane_inc  (lane_inc),
  .bank_we   (bank_we)
);

// File: tb/skew_word_mem_tb_top.sv
`timescale 1ns/1ps
module skew_word_mem_tb_top;
  localparam int ADDR_W = 8;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_be = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  bit          drv_rd = 1'b0;
  logic [7:0]  ref_mem [NBYTES];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  skew_word_mem #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = ref_mem[(a + i) % NBYTES];
    return w;
  endfunction

  task automatic acc(input bit wr, input int a, input logic [3:0] be,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(a);
    req_be    = be;
    req_wdata = d;
    drv_rd    = !wr;
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) ref_mem[(a + i) % NBYTES] = d[8*i +: 8];
    end else begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      drv_rd    = 1'b0;
    end
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done) break;
      if (!rst_n) begin
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      end else begin
        check("R2 rsp_valid timing", 32'(rsp_valid), 32'(drv_rd));
        if (rsp_valid) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected response", 32'd1, 32'd0);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rsp_rdata, e);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // Fill with aligned full-word writes (R5), distinct bytes
    for (int a = 0; a < NBYTES; a += 4)
      acc(1'b1, a, 4'hF, {8'(a+3) ^ 8'h5A, 8'(a+2) ^ 8'hC3, 8'(a+1) ^ 8'h96, 8'(a) ^ 8'h3C}, "R5");
    idle(1);

    // R3 aligned reads, back to back
    for (int a = 0; a < 64; a += 4) acc(1'b0, a, 4'h0, 32'h0, "R3 aligned read");
    // R4 every nonzero offset
    for (int a = 1; a < 48; a++)
      if (a % 4 != 0) acc(1'b0, a, 4'h0, 32'h0, "R4 unaligned read");
    idle(2);

    // R5 masked writes at every offset with 1-, 2-, 4-byte and sparse patterns
    for (int o = 0; o < 4; o++) begin
      acc(1'b1, 64 + o,      4'b0001, 32'hA1A2A3A4, "R5");
      acc(1'b1, 80 + o,      4'b0011, 32'hB1B2B3B4, "R5");
      acc(1'b1, 96 + o,      4'b1111, 32'hC1C2C3C4, "R5");
      acc(1'b1, 112 + o,     4'b1010, 32'hD1D2D3D4, "R5");
    end
    idle(1);
    for (int a = 60; a < 124; a++) acc(1'b0, a, 4'h0, 32'h0, "R5 masked write readback");
    idle(2);

    // R6 wrap at the top of memory
    for (int a = NBYTES - 4; a < NBYTES; a++) acc(1'b0, a, 4'h0, 32'h0, "R6 wrap read");
    acc(1'b1, NBYTES - 2, 4'hF, 32'hEEDDCCBB, "R6");
    acc(1'b1, NBYTES - 1, 4'b0110, 32'h11223344, "R6");
    idle(1);
    acc(1'b0, NBYTES - 3, 4'h0, 32'h0, "R6 wrap write readback");
    acc(1'b0, 0, 4'h0, 32'h0, "R6 row zero after wrap write");
    acc(1'b0, NBYTES - 1, 4'h0, 32'h0, "R6 wrap read after write");
    idle(2);

    // R7 write then immediate read, overlapping
    for (int o = 0; o < 4; o++) begin
      acc(1'b1, 140 + o, 4'b1101, 32'h0F1E2D3C + 32'(o), "R7");
      acc(1'b0, 139 + o, 4'h0, 32'h0, "R7 read right after write");
    end
    idle(2);

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      bit wr;
      a  = int'($urandom_range(NBYTES - 1, 0));
      wr = $urandom_range(1, 0) == 1;
      if (wr)
        acc(1'b1, a, 4'($urandom_range(15, 0)), $urandom, "R5");
      else if (a > NBYTES - 4)
        acc(1'b0, a, 4'h0, 32'h0, "R6 mixed read");
      else if (a % 4 == 0)
        acc(1'b0, a, 4'h0, 32'h0, "R3 mixed read");
      else
        acc(1'b0, a, 4'h0, 32'h0, "R4 mixed read");
      if (n % 7 == 0) idle(1);
    end
    idle(4);
    check("R2 responses outstanding", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule